// File: doc/BRIEF.md
# Subsystem Power-Up Sequencer

This block is a hardware state machine that takes a processor subsystem from held reset to running code without any software stepping. After a single start pulse it latches a boot vector, asserts the subsystem's stop and reset controls, and turns on the crystal clock branch. It then waits for that branch to report that it is running, and walks a power-control register image through headswitch enable, regulator bypass and retention release. Next it switches the memory banks on one at a time and removes the remaining clamps. Last, it releases the core from reset, enables its clock and lets it execute.

A free-running microsecond tick paces every wait, so the same netlist works at any core clock frequency. The clock-ready poll is bounded. If the branch never reports ready, the block drops every output back to its reset image and raises an error flag that stays set until the next start. The headswitch, regulator, memories and clock generators sit outside the block. They appear here only as the clock-off status input and as the registered control outputs.

Top module: `pwrup_seq`

## Requirements
- R1: Out of reset, `rstCtl` is 000, `xoClkEn`, `coreClkEn`, `seqDone` and `seqErr` are 0, `memBankEn` and `bootVec` are all zero, and `pwrCtl` is 0x0070_0000. In that image only the three clamp bits are set: IO clamp at bit 20, word-line clamp at bit 21 and memory clamp at bit 22.
- R2: A `startReq` seen while idle loads `bootVec` with `bootAddr[31:4]`, visible one clock later. In that same clock every other output returns to the R1 image, which clears `seqDone` and `seqErr`.
- R3: The first step sets `rstCtl` to 111, where bit 0 is stop-core, bit 1 is core reset and bit 2 is bus reset. The next step sets `xoClkEn`.
- R4: With `xoClkEn` on, the block samples `clkOffStat` once per `usTick`, for at most POLL_LIMIT (200) ticks. A low sample lets the sequence continue, including a low sample on the 200th tick.
- R5: If `clkOffStat` is still high on the 200th polled tick, every output, `bootVec` included, returns to the R1 image and `seqErr` rises. `seqErr` stays high until the next start.
- R6: After a successful poll, the block sets the headswitch bit (24) and waits SETTLE_US ticks. It then sets the regulator-bypass bit (25), then clears the memory clamp (bit 22), then sets the L2-standby-off bit (18) and the retention-off bit (19) together in one step.
- R7: The `memBankEn` bits are then set one per step, from index NUM_BANKS-1 down to index 0. Each bit stays set once on. The block waits at least SETTLE_US ticks after each bank before the next step.
- R8: After the last bank and its settle wait, the block clears the word-line clamp (bit 21) and then, in a separate step, the IO clamp (bit 20).
- R9: The block then clears `rstCtl` bit 1, then sets `coreClkEn`, then clears `rstCtl` bit 0 and raises `seqDone` in the same clock. `rstCtl` bit 2 stays set.
- R10: A `startReq` that arrives while a sequence is running has no effect. `bootVec` is unchanged, and the remaining output steps come out exactly as they would have without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| usTick | input | 1 | One-cycle pulse once per microsecond |
| startReq | input | 1 | Start pulse; honoured only when idle |
| bootAddr | input | ADDR_W | Byte boot address |
| clkOffStat | input | 1 | High while the crystal clock branch is still off |
| rstCtl | output | 3 | bit0 stop core, bit1 core reset, bit2 bus reset |
| xoClkEn | output | 1 | Crystal clock branch enable |
| pwrCtl | output | 32 | Power-control register image |
| memBankEn | output | NUM_BANKS | Per-bank memory power enables |
| coreClkEn | output | 1 | Core clock enable |
| bootVec | output | ADDR_W-4 | Boot vector, `bootAddr` shifted right by 4 |
| seqDone | output | 1 | Sequence finished, core running |
| seqErr | output | 1 | Sticky clock-ready timeout flag |

## Verification
Every output step appears exactly one clock after the edge that decides it. The untimed steps follow each other on consecutive clocks. A timed step lands on the clock after the tick that ends its wait, and a timeout lands on the edge of the 200th polled tick itself. The bench does not pin these steps to absolute cycles. Before each start it queues the ordered list of expected output images. A monitor then compares the outputs each half cycle away from the rising edge, and pops one queued image every time they change. Each time it pops an image, the monitor also checks the microsecond ticks counted since the previous change, where a settle wait applies, and the number of polled ticks at the poll exit. `bootVec` is checked on the falling edge right after the start pulse's capturing edge.

// File: rtl/pwrup_seq_pkg.sv
`timescale 1ns/1ps
package pwrup_seq_pkg;

  localparam int PWR_W        = 32;
  localparam int BIT_L2STBY   = 18;
  localparam int BIT_SLPRET   = 19;
  localparam int BIT_IOCLAMP  = 20;
  localparam int BIT_WLCLAMP  = 21;
  localparam int BIT_MEMCLAMP = 22;
  localparam int BIT_HEADSW   = 24;
  localparam int BIT_LDOBYP   = 25;

  localparam int RST_STOP = 0;
  localparam int RST_CORE = 1;
  localparam int RST_BUS  = 2;

  localparam logic [PWR_W-1:0] PWR_RESET_IMG =
      (PWR_W'(1) << BIT_IOCLAMP) | (PWR_W'(1) << BIT_WLCLAMP) | (PWR_W'(1) << BIT_MEMCLAMP);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ASSERT, ST_XO, ST_POLL, ST_HEADSW, ST_HEADSW_WAIT,
    ST_LDO, ST_MEMCLAMP, ST_RET, ST_BANK, ST_BANK_WAIT,
    ST_WLCLAMP, ST_IOCLAMP, ST_CORE, ST_CLK, ST_RUN
  } seqState_t;

  typedef struct packed {
    logic loadVec;
    logic abort;
    logic setRst;
    logic setXo;
    logic setHeadSw;
    logic setLdo;
    logic clrMemClamp;
    logic setRet;
    logic bankOn;
    logic clrWlClamp;
    logic clrIoClamp;
    logic relCore;
    logic setClk;
    logic relStop;
  } seqStrobe_t;

endpackage

// File: rtl/pwrup_seq_ctrl.sv
`timescale 1ns/1ps
module pwrup_seq_ctrl
  import pwrup_seq_pkg::*;
#(
  parameter int NUM_BANKS  = 20,
  parameter int POLL_LIMIT = 200,
  parameter int SETTLE_US  = 1,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              startReq,
  input  logic              clkOffStat,
  output seqStrobe_t        strobe,
  output logic [BANK_W-1:0] bankIdx,
  output logic              busy
);

  localparam int PCNT_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int WCNT_W = $clog2(SETTLE_US + 1);

  seqState_t         state, stateNxt;
  logic [PCNT_W-1:0] pollCnt;
  logic [WCNT_W-1:0] waitCnt;
  logic              pollLast, waitLast;

  assign pollLast = (pollCnt == PCNT_W'(POLL_LIMIT - 1));
  assign waitLast = (waitCnt == WCNT_W'(SETTLE_US - 1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    case (state)
      ST_IDLE:        if (startReq) begin strobe.loadVec = 1'b1; stateNxt = ST_ASSERT; end
      ST_ASSERT:      begin strobe.setRst = 1'b1; stateNxt = ST_XO; end
      ST_XO:          begin strobe.setXo = 1'b1; stateNxt = ST_POLL; end
      ST_POLL: begin
        if (usTick) begin
          if (!clkOffStat) stateNxt = ST_HEADSW;
          else if (pollLast) begin strobe.abort = 1'b1; stateNxt = ST_IDLE; end
        end
      end
      ST_HEADSW:      begin strobe.setHeadSw = 1'b1; stateNxt = ST_HEADSW_WAIT; end
      ST_HEADSW_WAIT: if (usTick && waitLast) stateNxt = ST_LDO;
      ST_LDO:         begin strobe.setLdo = 1'b1; stateNxt = ST_MEMCLAMP; end
      ST_MEMCLAMP:    begin strobe.clrMemClamp = 1'b1; stateNxt = ST_RET; end
      ST_RET:         begin strobe.setRet = 1'b1; stateNxt = ST_BANK; end
      ST_BANK:        begin strobe.bankOn = 1'b1; stateNxt = ST_BANK_WAIT; end
      ST_BANK_WAIT:   if (usTick && waitLast) stateNxt = (bankIdx == '0) ? ST_WLCLAMP : ST_BANK;
      ST_WLCLAMP:     begin strobe.clrWlClamp = 1'b1; stateNxt = ST_IOCLAMP; end
      ST_IOCLAMP:     begin strobe.clrIoClamp = 1'b1; stateNxt = ST_CORE; end
      ST_CORE:        begin strobe.relCore = 1'b1; stateNxt = ST_CLK; end
      ST_CLK:         begin strobe.setClk = 1'b1; stateNxt = ST_RUN; end
      ST_RUN:         begin strobe.relStop = 1'b1; stateNxt = ST_IDLE; end
      default:        stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pollCnt <= '0;
      waitCnt <= '0;
      bankIdx <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_XO) pollCnt <= '0;
      else if (state == ST_POLL && usTick) pollCnt <= pollCnt + 1'b1;
      if (state == ST_HEADSW || state == ST_BANK) waitCnt <= '0;
      else if ((state == ST_HEADSW_WAIT || state == ST_BANK_WAIT) && usTick) waitCnt <= waitCnt + 1'b1;
      if (state == ST_RET) bankIdx <= BANK_W'(NUM_BANKS - 1);
      else if (state == ST_BANK_WAIT && usTick && waitLast && bankIdx != '0) bankIdx <= bankIdx - 1'b1;
    end
  end

  // R4
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POLL) |-> (pollCnt < PCNT_W'(POLL_LIMIT)));

endmodule

// File: rtl/pwrup_seq_dp.sv
`timescale 1ns/1ps
module pwrup_seq_dp
  import pwrup_seq_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int ADDR_W    = 32,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int VEC_W    = ADDR_W - 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [BANK_W-1:0]    bankIdx,
  input  logic [ADDR_W-1:0]    bootAddr,
  output logic [2:0]           rstCtl,
  output logic                 xoClkEn,
  output logic [PWR_W-1:0]     pwrCtl,
  output logic [NUM_BANKS-1:0] memBankEn,
  output logic                 coreClkEn,
  output logic [VEC_W-1:0]     bootVec,
  output logic                 seqDone,
  output logic                 seqErr
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCtl    <= '0;
      xoClkEn   <= 1'b0;
      pwrCtl    <= PWR_RESET_IMG;
      memBankEn <= '0;
      coreClkEn <= 1'b0;
      bootVec   <= '0;
      seqDone   <= 1'b0;
      seqErr    <= 1'b0;
    end else begin
      if (strobe.loadVec || strobe.abort) begin
        rstCtl    <= '0;
        xoClkEn   <= 1'b0;
        pwrCtl    <= PWR_RESET_IMG;
        memBankEn <= '0;
        coreClkEn <= 1'b0;
        seqDone   <= 1'b0;
        seqErr    <= strobe.abort;
        bootVec   <= strobe.loadVec ? bootAddr[ADDR_W-1:4] : '0;
      end
      if (strobe.setRst)      rstCtl <= 3'b111;
      if (strobe.setXo)       xoClkEn <= 1'b1;
      if (strobe.setHeadSw)   pwrCtl[BIT_HEADSW] <= 1'b1;
      if (strobe.setLdo)      pwrCtl[BIT_LDOBYP] <= 1'b1;
      if (strobe.clrMemClamp) pwrCtl[BIT_MEMCLAMP] <= 1'b0;
      if (strobe.setRet) begin
        pwrCtl[BIT_L2STBY] <= 1'b1;
        pwrCtl[BIT_SLPRET] <= 1'b1;
      end
      if (strobe.bankOn)      memBankEn[bankIdx] <= 1'b1;
      if (strobe.clrWlClamp)  pwrCtl[BIT_WLCLAMP] <= 1'b0;
      if (strobe.clrIoClamp)  pwrCtl[BIT_IOCLAMP] <= 1'b0;
      if (strobe.relCore)     rstCtl[RST_CORE] <= 1'b0;
      if (strobe.setClk)      coreClkEn <= 1'b1;
      if (strobe.relStop) begin
        rstCtl[RST_STOP] <= 1'b0;
        seqDone          <= 1'b1;
      end
    end
  end

  // R7
  bank_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(memBankEn) && memBankEn != '0) |->
      ($countones(memBankEn) == $countones($past(memBankEn)) + 1));

  // R6
  ldo_after_headsw_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrCtl[BIT_LDOBYP]) |-> pwrCtl[BIT_HEADSW]);

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |-> (memBankEn == '0 && !xoClkEn && !coreClkEn && !seqDone));

endmodule

// File: rtl/pwrup_seq.sv
`timescale 1ns/1ps
module pwrup_seq
  import pwrup_seq_pkg::*;
#(
  parameter int NUM_BANKS  = 20,
  parameter int POLL_LIMIT = 200,
  parameter int SETTLE_US  = 1,
  parameter int ADDR_W     = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 usTick,
  input  logic                 startReq,
  input  logic [ADDR_W-1:0]    bootAddr,
  input  logic                 clkOffStat,
  output logic [2:0]           rstCtl,
  output logic                 xoClkEn,
  output logic [31:0]          pwrCtl,
  output logic [NUM_BANKS-1:0] memBankEn,
  output logic                 coreClkEn,
  output logic [ADDR_W-5:0]    bootVec,
  output logic                 seqDone,
  output logic                 seqErr
);

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  seqStrobe_t        strobe;
  logic [BANK_W-1:0] bankIdx;
  logic              busy;

  pwrup_seq_ctrl #(
    .NUM_BANKS(NUM_BANKS), .POLL_LIMIT(POLL_LIMIT), .SETTLE_US(SETTLE_US)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .usTick(usTick), .startReq(startReq),
    .clkOffStat(clkOffStat), .strobe(strobe), .bankIdx(bankIdx), .busy(busy)
  );

  pwrup_seq_dp #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bankIdx(bankIdx), .bootAddr(bootAddr),
    .rstCtl(rstCtl), .xoClkEn(xoClkEn), .pwrCtl(pwrCtl), .memBankEn(memBankEn),
    .coreClkEn(coreClkEn), .bootVec(bootVec), .seqDone(seqDone), .seqErr(seqErr)
  );

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> $stable(bootVec));

  // R9
  clk_after_core_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreClkEn) |-> !rstCtl[RST_CORE]);

  // R9
  done_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqDone) |-> (&memBankEn && coreClkEn && rstCtl == 3'b100));

endmodule

// File: tb/tb_pwrup_seq.sv
`timescale 1ns/1ps
module tb_pwrup_seq;

  localparam int NB = 20, POLL = 200, SETTLE = 1, AW = 32, TICK_DIV = 5;

  logic clk = 1'b0, rstN = 1'b0, usTick = 1'b0, startReq = 1'b0, clkOffStat = 1'b1;
  logic [AW-1:0] bootAddr = '0;
  logic [2:0] rstCtl;
  logic xoClkEn, coreClkEn, seqDone, seqErr;
  logic [31:0] pwrCtl;
  logic [NB-1:0] memBankEn;
  logic [AW-5:0] bootVec;

  always #2.5 clk = ~clk;

  pwrup_seq #(.NUM_BANKS(NB), .POLL_LIMIT(POLL), .SETTLE_US(SETTLE), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .startReq(startReq), .bootAddr(bootAddr),
    .clkOffStat(clkOffStat), .rstCtl(rstCtl), .xoClkEn(xoClkEn), .pwrCtl(pwrCtl),
    .memBankEn(memBankEn), .coreClkEn(coreClkEn), .bootVec(bootVec),
    .seqDone(seqDone), .seqErr(seqErr)
  );

  typedef struct packed {
    logic [2:0] rst; logic xo; logic [31:0] pwr; logic [NB-1:0] bank;
    logic cclk; logic done; logic err;
  } snap_t;

  typedef struct { snap_t s; bit settle; int poll; string req; } exp_t;

  localparam snap_t RESET_SNAP = '{rst: 3'b000, xo: 1'b0, pwr: 32'h0070_0000,
                                   bank: '0, cclk: 1'b0, done: 1'b0, err: 1'b0};

  exp_t  expQ[$];
  int    checks = 0, errors = 0;
  int    tickTotal = 0, lastChgTick = 0, pollTicks = 0, dropAt = 0;
  int    runId = 0, seenRun = 0, divCnt = 0, cyc = 0;
  bit    armPrev = 0, monOn = 0, finished = 0;
  snap_t prevSnap, model;

  function automatic snap_t curSnap();
    snap_t s;
    s.rst = rstCtl; s.xo = xoClkEn; s.pwr = pwrCtl; s.bank = memBankEn;
    s.cclk = coreClkEn; s.done = seqDone; s.err = seqErr;
    return s;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic pushExp(snap_t s, bit settle, int poll, string req);
    exp_t e;
    e.s = s; e.settle = settle; e.poll = poll; e.req = req;
    expQ.push_back(e);
  endtask

  // monitor: tick source, tick counting and scoreboard compare, all away from the rising edge
  always @(negedge clk) begin
    if (runId != seenRun) begin seenRun = runId; pollTicks = 0; end
    if (rstN) begin
      if (usTick) begin
        tickTotal++;
        if (armPrev) pollTicks++;
      end
      armPrev = xoClkEn && !seqErr && !pwrCtl[24];
      if (monOn && curSnap() !== prevSnap) begin
        snap_t c;
        c = curSnap();
        if (expQ.size() == 0) begin
          check(1'b0, "R10", "unexpected output change", 64'(c), 64'(prevSnap));
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(c === e.s, e.req, "output image", 64'(c), 64'(e.s));
          if (e.settle)
            check((tickTotal - lastChgTick) >= SETTLE, e.req, "settle ticks",
                  64'(tickTotal - lastChgTick), 64'(SETTLE));
          if (e.poll >= 0)
            check(pollTicks == e.poll, e.req, "polled ticks", 64'(pollTicks), 64'(e.poll));
        end
        lastChgTick = tickTotal;
        prevSnap = c;
      end
      clkOffStat = (pollTicks >= dropAt) ? 1'b0 : 1'b1;
      divCnt = (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
      usTick = (divCnt == 0);
    end
  end

  task automatic pulseStart(logic [AW-1:0] a);
    @(negedge clk);
    startReq = 1'b1; bootAddr = a;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic runSeq(logic [AW-1:0] a, int dropAtV, bit timeout, int pollExp, bit pokeBusy);
    if (model !== RESET_SNAP) pushExp(RESET_SNAP, 0, -1, "R2");
    model = RESET_SNAP;
    model.rst = 3'b111;   pushExp(model, 0, -1, "R3");
    model.xo  = 1'b1;     pushExp(model, 0, -1, "R3");
    if (timeout) begin
      model = RESET_SNAP; model.err = 1'b1;
      pushExp(model, 0, POLL, "R5");
    end else begin
      model.pwr[24] = 1'b1; pushExp(model, 0, pollExp, "R4");
      model.pwr[25] = 1'b1; pushExp(model, 1, -1, "R6");
      model.pwr[22] = 1'b0; pushExp(model, 0, -1, "R6");
      model.pwr[18] = 1'b1; model.pwr[19] = 1'b1; pushExp(model, 0, -1, "R6");
      for (int i = NB - 1; i >= 0; i--) begin
        model.bank[i] = 1'b1;
        pushExp(model, (i != NB - 1), -1, "R7");
      end
      model.pwr[21] = 1'b0; pushExp(model, 1, -1, "R8");
      model.pwr[20] = 1'b0; pushExp(model, 0, -1, "R8");
      model.rst[1]  = 1'b0; pushExp(model, 0, -1, "R9");
      model.cclk    = 1'b1; pushExp(model, 0, -1, "R9");
      model.rst[0]  = 1'b0; model.done = 1'b1; pushExp(model, 0, -1, "R9");
    end
    dropAt = dropAtV;
    runId++;
    pulseStart(a);
    check(bootVec === a[AW-1:4], "R2", "bootVec load", 64'(bootVec), 64'(a[AW-1:4]));
    if (pokeBusy) begin
      while (!memBankEn[10]) @(negedge clk);
      pulseStart(a ^ 32'hFFFF_0000);
      check(bootVec === a[AW-1:4], "R10", "bootVec after busy start", 64'(bootVec), 64'(a[AW-1:4]));
    end
    while (!(seqDone || seqErr)) @(negedge clk);
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, timeout ? "R5" : "R9", "pending expected steps",
          64'(expQ.size()), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset image
    check(rstCtl === 3'b000, "R1", "rstCtl", 64'(rstCtl), 64'd0);
    check(pwrCtl === 32'h0070_0000, "R1", "pwrCtl", 64'(pwrCtl), 64'h0070_0000);
    check(memBankEn === '0 && !xoClkEn && !coreClkEn, "R1", "banks/clocks",
          64'({memBankEn, xoClkEn, coreClkEn}), 64'd0);
    check(bootVec === '0 && !seqDone && !seqErr, "R1", "vec/done/err",
          64'({bootVec, seqDone, seqErr}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    model = RESET_SNAP;
    prevSnap = curSnap();
    monOn = 1'b1;

    runSeq(32'h1234_5670, 3, 1'b0, 4, 1'b0);        // R4 early success
    runSeq(32'hABCD_EF10, 0, 1'b0, 1, 1'b1);        // R10 busy start ignored
    runSeq(32'h0000_0F00, 1_000_000, 1'b1, 0, 1'b0); // R5 timeout
    check(seqErr === 1'b1, "R5", "sticky error", 64'(seqErr), 64'd1);
    check(bootVec === '0, "R5", "bootVec cleared", 64'(bootVec), 64'd0);
    runSeq(32'h8765_4320, POLL - 1, 1'b0, POLL, 1'b0); // R4 success on last try, clears R5 flag

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule